// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block produces the timing strobes that a serial transmitter and receiver step on. A 12-bit divisor sets a prescaler that counts down from the divisor value and reloads itself, so its underflow rate is the system clock divided by (divisor + 1). Each underflow is passed on as a receiver sample strobe. A second counter groups underflows into transmitter bit strobes. The group size is 16 in plain asynchronous operation, 8 when the double-speed control is set, and 2 in synchronous master operation. In master operation the block also drives a transfer clock with a period of 2 × (divisor + 1).

In synchronous slave operation the prescaler output is ignored. The incoming transfer clock goes through one synchronizing flop and then through an edge detector. The edge detector feeds the strobe registers. An edge-select input decides which detected edge launches transmit data; the opposite edge samples receive data. The shift logic, frame handling and register file sit outside and use only the strobes and the transfer clock.

Top module: `usart_clkgen`

## Requirements
- R1: In asynchronous mode (mode=0) and master mode (mode=1), `rx_tick` is a one-cycle strobe that repeats every divisor+1 cycles for any divisor from 0 to 4095. With divisor 0 it is high on every cycle.
- R2: In asynchronous mode with `dbl_speed`=0, `tx_tick` repeats every 16 × (divisor+1) cycles and always coincides with an `rx_tick`.
- R3: In asynchronous mode with `dbl_speed`=1, `tx_tick` repeats every 8 × (divisor+1) cycles.
- R4: In master mode, `xfer_clk_out` is a square wave that stays high for divisor+1 cycles in each period of 2 × (divisor+1). `tx_tick` repeats every 2 × (divisor+1) cycles and is high in exactly the cycle in which `xfer_clk_out` has just gone low.
- R5: `dbl_speed` has no effect in master mode or slave mode.
- R6: A `div_wr` pulse, or any change of `mode` or `dbl_speed`, restarts the prescaler from `div_value` and clears the group counter at once. In the cycle after the write edge no strobe is high. The first `rx_tick` appears after the divisor+1'th clock edge that follows the write edge, however far the old count had to go.
- R7: In slave mode (mode=2), a level change on `xfer_clk_in` shows up as a one-cycle strobe in the cycle after the second clock edge that sees the new level. With `edge_sel`=0 a rising edge gives `tx_tick` and a falling edge gives `rx_tick`; with `edge_sel`=1 the two are swapped. The prescaler makes no strobes in this mode.
- R8: `xfer_clk_out` is low whenever the mode is not master. Mode 3 produces no strobes at all.
- R9: While `rst_n` is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_value | input | 12 | Divisor register contents |
| div_wr | input | 1 | One-cycle pulse that marks a divisor write |
| mode | input | 2 | 0 asynchronous, 1 synchronous master, 2 synchronous slave, 3 idle |
| dbl_speed | input | 1 | Halves the asynchronous group size |
| edge_sel | input | 1 | Slave edge polarity: 0 launches on rising, 1 on falling |
| xfer_clk_in | input | 1 | External transfer clock used in slave mode |
| rx_tick | output | 1 | Receiver sample strobe |
| tx_tick | output | 1 | Transmitter bit strobe |
| xfer_clk_out | output | 1 | Transfer clock driven in master mode |

## Verification
A table of settings walks the divisor through 0, small values, 100 and 4095 in the asynchronous normal, asynchronous double-speed and master modes, and measures the strobe periods. The divisor-0 rows separate an off-by-one reload from a correct one. The 4095 rows expose counter truncation. Switching `dbl_speed` in master mode shows whether the control leaks outside asynchronous operation. Directed tests then rewrite the divisor part-way through a long count to show the restart. They also drive slave edges with both polarity settings to pin the two-cycle lag and the tx/rx swap, and they hold the input still with divisor 0 to prove the prescaler is muted in slave and idle modes.

// File: rtl/usart_clkgen.sv
module usart_clkgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_wr,
  input  logic [1:0]       mode,
  input  logic             dbl_speed,
  input  logic             edge_sel,
  input  logic             xfer_clk_in,
  output logic             rx_tick,
  output logic             tx_tick,
  output logic             xfer_clk_out
);
  localparam int GRP_W = 4;
  localparam logic [1:0] MODE_ASYNC  = 2'd0;
  localparam logic [1:0] MODE_MASTER = 2'd1;
  localparam logic [1:0] MODE_SLAVE  = 2'd2;
  localparam logic [GRP_W-1:0] LAST_NORM   = GRP_W'(15);
  localparam logic [GRP_W-1:0] LAST_DBL    = GRP_W'(7);
  localparam logic [GRP_W-1:0] LAST_MASTER = GRP_W'(1);

  logic [DIV_W-1:0] pre_cnt;
  logic [GRP_W-1:0] grp_cnt;
  logic [1:0]       mode_q;
  logic             dbl_q;
  logic             sync_q, hist_q;

  wire is_async  = (mode == MODE_ASYNC);
  wire is_master = (mode == MODE_MASTER);
  wire is_slave  = (mode == MODE_SLAVE);
  wire pre_run   = is_async | is_master;

  wire restart   = div_wr | (mode != mode_q) | (dbl_speed != dbl_q);
  wire underflow = (pre_cnt == '0) & ~restart;

  wire [GRP_W-1:0] grp_last = is_master ? LAST_MASTER : (dbl_speed ? LAST_DBL : LAST_NORM);
  wire grp_wrap = (grp_cnt == grp_last);

  wire ext_rise    = sync_q & ~hist_q;
  wire ext_fall    = ~sync_q & hist_q;
  wire launch_edge = edge_sel ? ext_fall : ext_rise;
  wire sample_edge = edge_sel ? ext_rise : ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt      <= '0;
      grp_cnt      <= '0;
      mode_q       <= MODE_ASYNC;
      dbl_q        <= 1'b0;
      sync_q       <= 1'b0;
      hist_q       <= 1'b0;
      rx_tick      <= 1'b0;
      tx_tick      <= 1'b0;
      xfer_clk_out <= 1'b0;
    end else begin
      mode_q <= mode;
      dbl_q  <= dbl_speed;
      sync_q <= xfer_clk_in;
      hist_q <= sync_q;

      if (restart || pre_cnt == '0) pre_cnt <= div_value;
      else                          pre_cnt <= pre_cnt - 1'b1;

      if (restart)        grp_cnt <= '0;
      else if (underflow) grp_cnt <= grp_wrap ? '0 : grp_cnt + 1'b1;

      rx_tick <= is_slave ? sample_edge : (pre_run & underflow);
      tx_tick <= is_slave ? launch_edge : (pre_run & underflow & grp_wrap);

      if (!is_master || restart) xfer_clk_out <= 1'b0;
      else if (underflow)        xfer_clk_out <= ~xfer_clk_out;
    end
  end
endmodule

// File: rtl/usart_clkgen_sva.sv
module usart_clkgen_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       div_wr,
  input logic [1:0] mode,
  input logic       edge_sel,
  input logic       xfer_clk_in,
  input logic       rx_tick,
  input logic       tx_tick,
  input logic       xfer_clk_out
);
  assert_tx_on_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && $past(mode) != 2'd2) |-> rx_tick);

  assert_tx_at_clk_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && $past(mode) == 2'd1 && $past(mode, 2) == 2'd1) |-> $fell(xfer_clk_out));

  assert_quiet_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_wr) && $past(mode) != 2'd2) |-> (!rx_tick && !tx_tick));

  assert_slave_launch_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && $past(mode) == 2'd2) |-> ($past(xfer_clk_in, 2) == !$past(edge_sel)));

  assert_slave_sample_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && $past(mode) == 2'd2) |-> ($past(xfer_clk_in, 2) == $past(edge_sel)));

  assert_slave_one_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2) |-> !(rx_tick && tx_tick));

  assert_clk_low_off_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != 2'd1) |-> !xfer_clk_out);
endmodule

bind usart_clkgen usart_clkgen_sva chk_i (.*);

// File: tb/usart_clkgen_tb_top.sv
module usart_clkgen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] div_value = '0;
  logic div_wr = 1'b0;
  logic [1:0] mode = 2'd0;
  logic dbl_speed = 1'b0;
  logic edge_sel = 1'b0;
  logic xfer_clk_in = 1'b0;
  logic rx_tick, tx_tick, xfer_clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usart_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .div_value(div_value), .div_wr(div_wr),
    .mode(mode), .dbl_speed(dbl_speed), .edge_sel(edge_sel),
    .xfer_clk_in(xfer_clk_in), .rx_tick(rx_tick), .tx_tick(tx_tick),
    .xfer_clk_out(xfer_clk_out)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic        dbl;
    logic [11:0] div;
    logic [31:0] rxp;
    logic [31:0] txp;
    logic [31:0] xcp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 12'd0,    32'd1,    32'd16,    32'd0},
    '{2'd0, 1'b0, 12'd5,    32'd6,    32'd96,    32'd0},
    '{2'd0, 1'b1, 12'd5,    32'd6,    32'd48,    32'd0},
    '{2'd0, 1'b1, 12'd0,    32'd1,    32'd8,     32'd0},
    '{2'd1, 1'b0, 12'd0,    32'd1,    32'd2,     32'd2},
    '{2'd1, 1'b1, 12'd9,    32'd10,   32'd20,    32'd20},
    '{2'd1, 1'b0, 12'd4095, 32'd4096, 32'd8192,  32'd8192},
    '{2'd0, 1'b1, 12'd4095, 32'd4096, 32'd32768, 32'd0},
    '{2'd0, 1'b0, 12'd100,  32'd101,  32'd1616,  32'd0},
    '{2'd0, 1'b0, 12'd4095, 32'd4096, 32'd0,     32'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic d, input logic [11:0] v);
    @(negedge clk);
    mode = m; dbl_speed = d; div_value = v; div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic measure(input int sel, input int limit, output int per);
    logic px, h;
    per = -1;
    px = xfer_clk_out;
    h = 1'b0;
    for (int n = 0; n < limit && !h; n++) begin
      @(negedge clk);
      h = (sel == 0) ? rx_tick : (sel == 1) ? tx_tick : (xfer_clk_out & ~px);
      px = xfer_clk_out;
    end
    if (!h) return;
    h = 1'b0;
    for (int n = 1; n <= limit && !h; n++) begin
      @(negedge clk);
      h = (sel == 0) ? rx_tick : (sel == 1) ? tx_tick : (xfer_clk_out & ~px);
      px = xfer_clk_out;
      if (h) per = n;
    end
  endtask

  task automatic slave_edge(input logic lvl, input string req);
    logic exp_tx;
    exp_tx = lvl ^ edge_sel;
    @(negedge clk);
    xfer_clk_in = lvl;
    @(negedge clk);
    chk({req, " no strobe one edge after change"}, int'(rx_tick | tx_tick), 0);
    @(negedge clk);
    chk({req, " tx strobe two edges after change"}, int'(tx_tick), int'(exp_tx));
    chk({req, " rx strobe two edges after change"}, int'(rx_tick), int'(!exp_tx));
    @(negedge clk);
    chk({req, " strobe lasts one cycle"}, int'(rx_tick | tx_tick), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic count_quiet(input int cycles, input string req);
    int hits;
    hits = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      hits += int'(rx_tick) + int'(tx_tick) + int'(xfer_clk_out);
    end
    chk(req, hits, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int per, high;
    logic px;
    string treq;
    repeat (3) @(negedge clk);
    chk("R9 outputs low in reset", int'(rx_tick | tx_tick | xfer_clk_out), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_cfg(VECS[i].md, VECS[i].dbl, VECS[i].div);
      measure(0, 2 * int'(VECS[i].rxp) + 20, per);
      chk($sformatf("R1 rx period vec %0d", i), per, int'(VECS[i].rxp));
      treq = (VECS[i].md == 2'd1) ? (VECS[i].dbl ? "R5" : "R4") : (VECS[i].dbl ? "R3" : "R2");
      if (VECS[i].txp != 0) begin
        measure(1, 2 * int'(VECS[i].txp) + 20, per);
        chk($sformatf("%s tx period vec %0d", treq, i), per, int'(VECS[i].txp));
      end
      if (VECS[i].xcp != 0) begin
        measure(2, 2 * int'(VECS[i].xcp) + 20, per);
        chk($sformatf("%s clock period vec %0d", treq, i), per, int'(VECS[i].xcp));
      end
    end

    // R4: high width and tx alignment with clock fall
    write_cfg(2'd1, 1'b0, 12'd3);
    px = xfer_clk_out;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (xfer_clk_out && !px) break;
      px = xfer_clk_out;
    end
    high = 1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (!xfer_clk_out) break;
      high++;
    end
    chk("R4 clock high width", high, 4);
    chk("R4 tx strobe on clock fall", int'(tx_tick), 1);

    // R6: write mid-count restarts immediately
    write_cfg(2'd0, 1'b0, 12'd200);
    repeat (57) @(negedge clk);
    div_value = 12'd3;
    div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
    chk("R6 no strobe right after write", int'(rx_tick | tx_tick), 0);
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      chk($sformatf("R6 rx after write edge %0d", n), int'(rx_tick), (n == 4) ? 1 : 0);
    end
    measure(1, 100, per);
    chk("R6 tx period after rewrite", per, 64);

    // R8: async and idle keep the transfer clock low
    write_cfg(2'd0, 1'b0, 12'd0);
    high = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      high += int'(xfer_clk_out);
    end
    chk("R8 clock low in async", high, 0);
    write_cfg(2'd3, 1'b0, 12'd0);
    count_quiet(40, "R8 idle mode silent");

    // R7: slave mode
    xfer_clk_in = 1'b0;
    edge_sel = 1'b0;
    write_cfg(2'd2, 1'b0, 12'd0);
    count_quiet(30, "R7 prescaler muted in slave");
    slave_edge(1'b1, "R7 sel0 rise");
    slave_edge(1'b0, "R7 sel0 fall");
    edge_sel = 1'b1;
    repeat (3) @(negedge clk);
    slave_edge(1'b1, "R7 sel1 rise");
    slave_edge(1'b0, "R7 sel1 fall");
    write_cfg(2'd2, 1'b1, 12'd0);
    slave_edge(1'b1, "R5 slave dbl rise");
    slave_edge(1'b0, "R5 slave dbl fall");

    // R9: reset mid-run
    write_cfg(2'd1, 1'b0, 12'd0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 outputs cleared by reset", int'(rx_tick | tx_tick | xfer_clk_out), 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule